// File: doc/BRIEF.md
# Program-Space Data Window Mapper

This block sits between a data-bus requester and two memories: a 64 KB data RAM and a 24-bit-wide program memory. Reads to the lower 32 KB of the data space go straight to data RAM and complete in the same cycle. Reads to the upper 32 KB are redirected into program memory. An 8-bit page register chooses which 16K-instruction-word region of the lower, user half of program space appears in that window.

A windowed read costs one extra cycle. The block drops `ready` for one cycle, fetches the instruction word, and returns only its low 16 bits. The top 8 bits of every program word cannot be reached through this path.

Byte reads pick one lane of the 16-bit result with address bit 0 and zero-extend it. The requester holds its address and strobe until `ready` is high. A page write that arrives while a windowed read is starting does not disturb that read.

Top module: `psv_window_map`

## Requirements
- R1: After reset the page register is 0, and with no request `ready` is 1 while `pm_rd` and `ram_rd` are 0.
- R2: A read with `req_addr[15]`=0 asserts `ram_rd` with `ram_addr`=`req_addr`, keeps `pm_rd` at 0, holds `ready` at 1 in that cycle, and returns `ram_rdata` in the same cycle.
- R3: A read with `req_addr[15]`=1 asserts `pm_rd` in its first cycle. In that cycle `pm_addr` = {1'b0, page[7:0], req_addr[14:1], 1'b0}, a 24-bit byte address whose top bit and bit 0 are zero.
- R4: A windowed read holds `ready` at 0 for exactly one cycle. `ready` is 1 in the following cycle, when the result is valid. `pm_rd` is asserted for one cycle per windowed read.
- R5: A windowed word read returns `pm_rdata[15:0]`, which program memory delivers in the cycle after `pm_rd`. Bits 23:16 of the program word never reach `rdata`.
- R6: When `req_byte`=1, `rdata` = {8'h00, low byte} if `req_addr[0]`=0, and {8'h00, high byte} if `req_addr[0]`=1. This applies on both paths. When `req_byte`=0, `req_addr[0]` is ignored.
- R7: A page write takes effect from the next access that starts after the write's clock edge. A windowed read that starts in the same cycle as a page write uses the old page. The read keeps `pm_addr` unchanged through its second cycle.
- R8: With `req_rd`=0 the block issues no memory read, and `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read strobe from the requester |
| req_addr | input | 16 | Data-space byte address |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| page_we | input | 1 | Page register write enable |
| page_wdata | input | 8 | New page value |
| ram_rd | output | 1 | Data RAM read strobe |
| ram_addr | output | 16 | Data RAM byte address |
| ram_rdata | input | 16 | Data RAM read data, combinational |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | 24 | Program memory byte address |
| pm_rdata | input | 24 | Program word, valid the cycle after pm_rd |
| rdata | output | 16 | Read result, valid while req_rd and ready |
| ready | output | 1 | 0 while a windowed read is stalled |

## Verification
The bench targets the following corner cases:

- Addresses 0x7FFE and 0x8000, either side of the window boundary. Getting the split wrong would stall a RAM read or send a windowed read to RAM.
- Pages 0x00 and 0xFF combined with the lowest and highest window offsets. A misplaced page or offset field, or an uncleared top bit, shows up as a wrong `pm_addr` and wrong data.
- Back-to-back windowed reads. A design that skipped the stall or stalled twice would report the wrong number of low-`ready` cycles.
- A page write in the first cycle of a windowed read. A design without a latched page would change `pm_addr` mid-access.
- Byte reads on both lanes of both paths. A lane swap or missing zero-extension corrupts `rdata`.

Program words carry a nonzero top byte, so leaking those bits would be caught.

// File: rtl/psv_pkg.sv
package psv_pkg;

    localparam int DWORD_W = 16;
    localparam int HALF_W  = DWORD_W / 2;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic byte_mode;
        logic hi_lane;
    } lane_sel_t;

    function automatic logic [DWORD_W-1:0] lane_pick(input logic [DWORD_W-1:0] word,
                                                     input lane_sel_t sel);
        logic [DWORD_W-1:0] res;
        if (!sel.byte_mode)
            res = word;
        else if (sel.hi_lane)
            res = {{HALF_W{1'b0}}, word[DWORD_W-1:HALF_W]};
        else
            res = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
        return res;
    endfunction

endpackage

// File: rtl/psv_page_reg.sv
module psv_page_reg #(
    parameter int PG_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [PG_W-1:0] wdata,
    output logic [PG_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst)
            page <= '0;
        else if (we)
            page <= wdata;
    end

    // R1
    page_reset_zero_chk: assert property (@(posedge clk) $past(rst) |-> (page == '0));
endmodule

// File: rtl/psv_xlate.sv
module psv_xlate #(
    parameter int DA_W  = 16,
    parameter int PG_W  = 8,
    parameter int PM_AW = 24
) (
    input  logic [DA_W-1:0]  addr,
    input  logic [PG_W-1:0]  page,
    output logic             win,
    output logic [PM_AW-1:0] pm_addr
);
    localparam int OFF_W = DA_W - 2;
    localparam int PAD_W = PM_AW - PG_W - OFF_W - 1;

    assign win = addr[DA_W-1];

    generate
        if (PAD_W > 0) begin : g_pad
            assign pm_addr = {{PAD_W{1'b0}}, page, addr[DA_W-2:1], 1'b0};
        end else begin : g_nopad
            assign pm_addr = {page, addr[DA_W-2:1], 1'b0};
        end
    endgenerate
endmodule

// File: rtl/psv_seq.sv
module psv_seq
    import psv_pkg::*;
#(
    parameter int PG_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [PG_W-1:0] page_now,
    output logic            fetch,
    output logic            waiting,
    output logic [PG_W-1:0] page_eff
);
    seq_state_e      state_q;
    logic [PG_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            page_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start) begin
                    state_q <= SEQ_WAIT;
                    page_q  <= page_now;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign fetch    = (state_q == SEQ_IDLE) && start;
    assign waiting  = (state_q == SEQ_WAIT);
    assign page_eff = waiting ? page_q : page_now;

    // R7
    latched_page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fetch |=> (page_eff == $past(page_now)));
endmodule

// File: rtl/psv_lane.sv
module psv_lane
    import psv_pkg::*;
#(
    parameter int PM_DW = 24
) (
    input  logic               from_pm,
    input  logic [DWORD_W-1:0] ram_rdata,
    input  logic [PM_DW-1:0]   pm_rdata,
    input  logic               byte_mode,
    input  logic               hi_lane,
    output logic [DWORD_W-1:0] rdata
);
    logic [DWORD_W-1:0] word;
    logic               pm_hi_unused;
    lane_sel_t          sel;

    assign pm_hi_unused = ^pm_rdata[PM_DW-1:DWORD_W];
    assign word         = from_pm ? pm_rdata[DWORD_W-1:0] : ram_rdata;
    assign sel          = '{byte_mode: byte_mode, hi_lane: hi_lane};
    assign rdata        = lane_pick(word, sel);
endmodule

// File: rtl/psv_window_map.sv
module psv_window_map
    import psv_pkg::*;
#(
    parameter int DA_W  = 16,
    parameter int PG_W  = 8,
    parameter int PM_AW = 24,
    parameter int PM_DW = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_rd,
    input  logic [DA_W-1:0]    req_addr,
    input  logic               req_byte,
    input  logic               page_we,
    input  logic [PG_W-1:0]    page_wdata,
    output logic               ram_rd,
    output logic [DA_W-1:0]    ram_addr,
    input  logic [DWORD_W-1:0] ram_rdata,
    output logic               pm_rd,
    output logic [PM_AW-1:0]   pm_addr,
    input  logic [PM_DW-1:0]   pm_rdata,
    output logic [DWORD_W-1:0] rdata,
    output logic               ready
);
    logic [PG_W-1:0] page_reg;
    logic [PG_W-1:0] page_eff;
    logic            win;
    logic            fetch;
    logic            waiting;

    psv_page_reg #(.PG_W(PG_W)) page_i (
        .clk(clk), .rst(rst), .we(page_we), .wdata(page_wdata), .page(page_reg)
    );

    psv_seq #(.PG_W(PG_W)) seq_i (
        .clk(clk), .rst(rst), .start(req_rd && win), .page_now(page_reg),
        .fetch(fetch), .waiting(waiting), .page_eff(page_eff)
    );

    psv_xlate #(.DA_W(DA_W), .PG_W(PG_W), .PM_AW(PM_AW)) xlate_i (
        .addr(req_addr), .page(page_eff), .win(win), .pm_addr(pm_addr)
    );

    psv_lane #(.PM_DW(PM_DW)) lane_i (
        .from_pm(win), .ram_rdata(ram_rdata), .pm_rdata(pm_rdata),
        .byte_mode(req_byte), .hi_lane(req_addr[0]), .rdata(rdata)
    );

    assign ram_rd   = req_rd && !win;
    assign ram_addr = req_addr;
    assign pm_rd    = fetch;
    assign ready    = !fetch;

    // R2
    ram_path_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (req_rd && !req_addr[DA_W-1]) |-> (ready && !pm_rd));
    // R4
    single_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (req_rd && !ready) |=> ready);
    // R4
    single_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        pm_rd |=> !pm_rd);
    // R7
    held_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_rd && !ready) |=> $stable(pm_addr));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_rd |-> (ready && !pm_rd && !ram_rd));
endmodule

// File: tb/psv_window_map_tb.sv
module psv_window_map_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_rd = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_byte = 1'b0;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic        ram_rd;
    logic [15:0] ram_addr;
    logic [15:0] ram_rdata;
    logic        pm_rd;
    logic [23:0] pm_addr;
    logic [23:0] pm_rdata = '0;
    logic [15:0] rdata;
    logic        ready;

    always #4 clk = ~clk;

    psv_window_map dut_i (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_addr(req_addr), .req_byte(req_byte),
        .page_we(page_we), .page_wdata(page_wdata), .ram_rd(ram_rd), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
        .rdata(rdata), .ready(ready)
    );

    function automatic logic [15:0] ramf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h6D2B;
    endfunction

    function automatic logic [23:0] pmf(input logic [23:0] a);
        return {8'hC3 ^ a[8:1], a[16:1] ^ {2'b00, a[22:17], 8'h00} ^ 16'h1357};
    endfunction

    assign ram_rdata = ramf(ram_addr);
    always @(posedge clk) if (pm_rd) pm_rdata <= pmf(pm_addr);

    typedef struct {
        logic [15:0] data;
        logic        win;
        logic [23:0] pa;
        logic [15:0] ra;
        string       tag;
    } exp_t;

    exp_t        scb[$];
    int          total = 0;
    int          bad = 0;
    logic [7:0]  model_page = 8'h00;
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pick(input logic [15:0] w, input logic bm, input logic hi);
        if (!bm) return w;
        return hi ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic rd(input logic [15:0] a, input logic bm, input string tag,
                      input bit wr_en = 1'b0, input logic [7:0] wr_val = 8'h00);
        exp_t e;
        bit   r;
        bit   first;
        e.win = a[15];
        e.pa  = {1'b0, model_page, a[14:1], 1'b0};
        e.ra  = a;
        e.tag = tag;
        e.data = e.win ? pick(pmf(e.pa)[15:0], bm, a[0]) : pick(ramf(a), bm, a[0]);
        scb.push_back(e);
        req_rd = 1'b1; req_addr = a; req_byte = bm;
        page_we = wr_en; page_wdata = wr_val;
        first = 1'b1;
        do begin
            @(negedge clk); r = ready;
            @(posedge clk); #2;
            if (first && wr_en) begin
                page_we = 1'b0;
                model_page = wr_val;
            end
            first = 1'b0;
        end while (!r);
        req_rd = 1'b0;
    endtask

    task automatic wr_page(input logic [7:0] v);
        page_we = 1'b1; page_wdata = v;
        @(posedge clk); #2;
        page_we = 1'b0;
        model_page = v;
    endtask

    // monitor: pops expected items as results appear
    int          stalls = 0;
    logic [23:0] held_pa = '0;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (!req_rd) begin
                chk(ready && !pm_rd && !ram_rd, "R8 idle quiet", {29'd0, ready, pm_rd, ram_rd}, 32'h4);
            end else if (scb.size() == 0) begin
                chk(1'b0, "scoreboard empty", 0, 1);
            end else if (!ready) begin
                if (stalls == 0) begin
                    chk(pm_rd, {"R3 pm_rd ", scb[0].tag}, pm_rd, 1);
                    chk(pm_addr == scb[0].pa, {"R3 pm_addr ", scb[0].tag}, pm_addr, scb[0].pa);
                    held_pa = pm_addr;
                end
                stalls++;
            end else begin
                exp_t e;
                e = scb.pop_front();
                if (e.win) begin
                    chk(stalls == 1, {"R4 stall count ", e.tag}, stalls, 1);
                    chk(pm_addr == held_pa, {"R7 held pm_addr ", e.tag}, pm_addr, held_pa);
                    chk(!pm_rd, {"R4 no refetch ", e.tag}, pm_rd, 0);
                end else begin
                    chk(stalls == 0, {"R2 no stall ", e.tag}, stalls, 0);
                    chk(ram_rd && !pm_rd, {"R2 ram_rd ", e.tag}, {ram_rd, pm_rd}, 2'b10);
                    chk(ram_addr == e.ra, {"R2 ram_addr ", e.tag}, ram_addr, e.ra);
                end
                chk(rdata == e.data, {"data ", e.tag}, rdata, e.data);
                stalls = 0;
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(ready && !pm_rd && !ram_rd, "R1 reset outputs", {ready, pm_rd, ram_rd}, 3'b100);
        @(posedge clk); #2;
        rd(16'h8000, 1'b0, "R1 R3 page zero after reset");
        rd(16'h1234, 1'b0, "R2 ram word");
        rd(16'h7FFE, 1'b0, "R2 ram top boundary");
        rd(16'h0000, 1'b0, "R2 ram bottom");
        rd(16'h7FFF, 1'b0, "R6 word ignores bit0 ram");
        rd(16'h4567, 1'b1, "R6 ram byte high");
        rd(16'h4566, 1'b1, "R6 ram byte low");
        wr_page(8'hFF);
        rd(16'hFFFE, 1'b0, "R3 R5 top page top offset");
        rd(16'h8000, 1'b0, "R3 R5 top page low offset");
        wr_page(8'h5A);
        rd(16'hA5A4, 1'b0, "R5 window word");
        rd(16'hA5A5, 1'b1, "R6 window byte high");
        rd(16'hA5A4, 1'b1, "R6 window byte low");
        rd(16'hC001, 1'b0, "R6 window word ignores bit0");
        rd(16'h9000, 1'b0, "R4 back to back a");
        rd(16'h9002, 1'b0, "R4 back to back b");
        rd(16'h0100, 1'b0, "R2 after window");
        rd(16'hB00C, 1'b0, "R7 write during stall", 1'b1, 8'h21);
        rd(16'hB00C, 1'b0, "R7 new page next access");
        rd(16'h2000, 1'b0, "R7 write during ram read", 1'b1, 8'h03);
        rd(16'h8ABC, 1'b0, "R7 page after ram-cycle write");
        repeat (2) @(posedge clk);
        chk(scb.size() == 0, "scoreboard drained", scb.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule